// File: doc/BRIEF.md
# Table-Access Mailbox Responder

This block serves reads of a small device-attribute table through a pair of dword mailboxes. A host writes a request into the write mailbox, one dword per strobe, and then raises a one-cycle request-valid pulse. The request names an entry handle. If the request is long enough and the handle exists, the block looks the entry up in an internal ROM. Each ROM entry has a byte base and a byte length. The block then fills the read mailbox with a three-dword response header followed by the entry's bytes, packed little-endian into dwords.

The header returns the handle of the following entry. A host can therefore start at handle 0 and keep feeding the returned handle back until it sees the end marker 0xFFFF. The read mailbox fills at one dword per cycle. While it fills, `busy` is high. `done` marks completion and is the point at which the response-length counter grows by the size of the response.

The table holds six entries and their contents are computed, not stored. The memory size reported by two of the entries is a parameter.

Top module: `table_access_resp`

## Requirements
- R1: A request whose length field (write-mailbox dword 1, bits [17:0], in dwords) is below 3 is dropped. No busy, no done, the length counter is unchanged and the read mailbox is untouched.
- R2: A request whose handle (write-mailbox dword 2, bits [31:16]) is 6 or more is dropped in the same way, and the ROM is never addressed outside its six entries.
- R3: Response dword 0 holds vendor code 0x1E98 in [15:0], object type 2 in [23:16] and zero in [31:24].
- R4: Response dword 1 holds, in [17:0], the value ceil((12 + entry length in bytes) / 4), with zero above it. The entry lengths are 24 bytes for handles 0 and 5 and 22 bytes for handles 1 to 4, so every response is 9 dwords.
- R5: Response dword 2 holds response code 0 in [7:0] and table type 0 in [15:8]. Bits [31:16] hold the requested handle plus one, or 0xFFFF when handle 5 (the last entry) was requested.
- R6: Entry bytes start at response dword 3, with entry byte 4k+j in bits [8j+7:8j] of dword 3+k. Bytes past the entry's length in the last dword read as zero.
- R7: Entry contents, as byte offset: value, with multi-byte fields little-endian and every other byte zero:
  - Handle 0, memory affinity: 0:0, 2-3:24, 5:0x04 (non-volatile flag), 16-23:memory size.
  - Handles 1 to 4: 0:1, 2-3:22, 6:data kind, 8-15:base unit, 16-17:value.
    - Handle 1, read latency: kind 1, unit 10000, value 15.
    - Handle 2, write latency: kind 2, unit 10000, value 25.
    - Handle 3, read bandwidth: kind 4, unit 1000, value 16.
    - Handle 4, write bandwidth: kind 5, unit 1000, value 16.
  - Handle 5, memory type: 0:4, 2-3:24, 5:2 (type attribute), 16-23:memory size.
- R8: `rsp_len` resets to 0. It grows by the response's dword-1 length value in the cycle `done` is high, and changes at no other time.
- R9: `busy` rises the cycle after an accepted request and stays high for exactly as many cycles as the response has dwords. `done` is then high for one cycle, with `busy` low.
- R10: A request-valid pulse while `busy` is high is ignored. It produces no extra response and does not alter the response in progress.
- R11: After reset, `busy` and `done` are low and `rsp_len` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_wr_en | input | 1 | Write-mailbox dword write strobe |
| mb_wr_idx | input | $clog2(WMB_DEPTH) | Write-mailbox dword index |
| mb_wr_data | input | 32 | Write-mailbox dword data |
| req_valid | input | 1 | One-cycle pulse: the request in the write mailbox is complete |
| rsp_rd_idx | input | $clog2(RMB_DEPTH) | Read-mailbox dword index |
| rsp_rd_data | output | 32 | Read-mailbox dword at `rsp_rd_idx` (combinational) |
| rsp_len | output | LEN_W | Accumulated response length in dwords |
| busy | output | 1 | Response being written |
| done | output | 1 | One-cycle pulse when a response is complete |

## Verification
The bench walks the table by feeding each returned handle back as the next request. A wrong sentinel on handle 5 would therefore leave the walk stuck or send it past the table. A wrong length rounding would show up as a bad dword-1 value or wrong busy duration on the 22-byte entries.

Requests with lengths 0 and 2 and handles 6 and 0xFFFF must leave busy, done, `rsp_len` and the previously returned header unchanged. A design that accepted them would raise done or corrupt the mailbox.

A second request pulse sent mid-response must not add a response. Every data dword is compared against a separately built byte image, including the zero padding after the last valid byte.

// File: rtl/tar_pkg.sv
`timescale 1ns/1ps
package tar_pkg;

    localparam int N_ENT    = 6;
    localparam int EW       = $clog2(N_ENT);
    localparam int HDR_DW   = 3;
    localparam int REQ_DW   = 3;
    localparam int LEN_FW   = 18;
    localparam int ROM_BYTES = 2 * 24 + 4 * 22;
    localparam int ROM_AW   = $clog2(ROM_BYTES);

    localparam logic [15:0] END_HANDLE = 16'hFFFF;
    localparam logic [15:0] VENDOR     = 16'h1E98;
    localparam logic [7:0]  OBJ_TYPE   = 8'd2;
    localparam logic [7:0]  RSP_CODE   = 8'd0;
    localparam logic [7:0]  TBL_TYPE   = 8'd0;
    localparam logic [15:0] BW_VALUE   = 16'd16;

    typedef enum logic [0:0] {ST_IDLE, ST_FILL} st_e;

    typedef struct packed {
        logic [15:0]       handle;
        logic [LEN_FW-1:0] obj_len;
    } req_t;

    typedef struct packed {
        logic [7:0]  rsvd;
        logic [7:0]  obj_type;
        logic [15:0] vendor;
    } hdr0_t;

    typedef struct packed {
        logic [15:0] next_handle;
        logic [7:0]  tbl_type;
        logic [7:0]  rsp_code;
    } hdr2_t;

    function automatic logic [15:0] ent_len(input logic [EW-1:0] e);
        return (e == EW'(0) || e == EW'(5)) ? 16'd24 : 16'd22;
    endfunction

    function automatic logic [15:0] ent_base(input logic [EW-1:0] e);
        logic [15:0] s;
        s = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (EW'(i) < e) s = s + ent_len(EW'(i));
        end
        return s;
    endfunction

    function automatic logic [LEN_FW-1:0] hdr_len_dw(input logic [15:0] len_b);
        logic [LEN_FW-1:0] t;
        t = LEN_FW'(HDR_DW * 4) + LEN_FW'(len_b) + LEN_FW'(3);
        return t >> 2;
    endfunction

    function automatic logic [7:0] lb_kind(input logic [EW-1:0] e);
        case (e)
            EW'(1):  return 8'd1;
            EW'(2):  return 8'd2;
            EW'(3):  return 8'd4;
            EW'(4):  return 8'd5;
            default: return 8'd0;
        endcase
    endfunction

    // Byte at offset 'off' of entry 'e'
    function automatic logic [7:0] ent_byte(input logic [EW-1:0] e,
                                            input logic [7:0] off,
                                            input logic [63:0] msz);
        logic [63:0] unit;
        logic [15:0] val;
        logic [15:0] len;
        logic [7:0]  b;
        logic        is_lb;
        is_lb = (e >= EW'(1)) && (e <= EW'(4));
        len   = ent_len(e);
        unit  = (e <= EW'(2)) ? 64'd10000 : 64'd1000;
        val   = (e == EW'(1)) ? 16'd15 : (e == EW'(2)) ? 16'd25 : BW_VALUE;
        b     = '0;
        if (off == 8'd0)
            b = (e == EW'(0)) ? 8'd0 : (is_lb ? 8'd1 : 8'd4);
        else if (off == 8'd2)
            b = len[7:0];
        else if (off == 8'd3)
            b = len[15:8];
        else if (off == 8'd5)
            b = (e == EW'(0)) ? 8'h04 : ((e == EW'(5)) ? 8'h02 : 8'h00);
        else if (off == 8'd6 && is_lb)
            b = lb_kind(e);
        else if (off >= 8'd8 && off <= 8'd15 && is_lb)
            b = 8'(unit >> {off - 8'd8, 3'b000});
        else if (off >= 8'd16 && off <= 8'd23 && !is_lb)
            b = 8'(msz >> {off - 8'd16, 3'b000});
        else if (off == 8'd16 && is_lb)
            b = val[7:0];
        else if (off == 8'd17 && is_lb)
            b = val[15:8];
        return b;
    endfunction

    // Byte at flat ROM address: find the owning entry by base/length
    function automatic logic [7:0] flat_byte(input logic [ROM_AW-1:0] addr,
                                             input logic [63:0] msz);
        logic [15:0] a;
        logic [15:0] bs;
        logic [7:0]  b;
        a = 16'(addr);
        b = '0;
        for (int i = 0; i < N_ENT; i++) begin
            bs = ent_base(EW'(i));
            if (a >= bs && a < bs + ent_len(EW'(i)))
                b = ent_byte(EW'(i), 8'(a - bs), msz);
        end
        return b;
    endfunction

endpackage

// File: rtl/tar_rom.sv
`timescale 1ns/1ps
module tar_rom
    import tar_pkg::*;
#(
    parameter int          KW       = 4,
    parameter logic [63:0] MEM_SIZE = 64'h1000_0000
) (
    input  logic [EW-1:0] ent,
    input  logic [KW-1:0] dw_k,
    output logic [31:0]   dword
);
    logic [15:0] base_b;
    logic [15:0] len_b;
    logic [15:0] off0;

    assign base_b = ent_base(ent);
    assign len_b  = ent_len(ent);
    assign off0   = 16'({dw_k, 2'b00});

    for (genvar ln = 0; ln < 4; ln++) begin : g_lane
        logic [15:0] off;
        logic [ROM_AW-1:0] addr;
        assign off  = off0 + 16'(ln);
        assign addr = ROM_AW'(base_b + off);
        assign dword[8*ln +: 8] = (off < len_b) ? flat_byte(addr, MEM_SIZE) : 8'h00;
    end
endmodule

// File: rtl/tar_wr_mbox.sv
`timescale 1ns/1ps
module tar_wr_mbox
    import tar_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wen,
    input  logic [AW-1:0] widx,
    input  logic [31:0]   wdata,
    output req_t          req
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wen) begin
            mem[widx] <= wdata;
        end
    end

    assign req.obj_len = mem[1][LEN_FW-1:0];
    assign req.handle  = mem[2][31:16];
endmodule

// File: rtl/tar_rd_mbox.sv
`timescale 1ns/1ps
module tar_rd_mbox #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wen,
    input  logic [AW-1:0] widx,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] ridx,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wen) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/table_access_resp.sv
`timescale 1ns/1ps
module table_access_resp
    import tar_pkg::*;
#(
    parameter int          WMB_DEPTH = 8,
    parameter int          RMB_DEPTH = 16,
    parameter int          LEN_W     = 16,
    parameter logic [63:0] MEM_SIZE  = 64'h1000_0000,
    localparam int         WA        = $clog2(WMB_DEPTH),
    localparam int         RA        = $clog2(RMB_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mb_wr_en,
    input  logic [WA-1:0]    mb_wr_idx,
    input  logic [31:0]      mb_wr_data,
    input  logic             req_valid,
    input  logic [RA-1:0]    rsp_rd_idx,
    output logic [31:0]      rsp_rd_data,
    output logic [LEN_W-1:0] rsp_len,
    output logic             busy,
    output logic             done
);
    req_t              req;
    st_e               st;
    logic [EW-1:0]     cur_ent;
    logic [RA-1:0]     ptr;
    logic [LEN_FW-1:0] tot;
    logic              done_r;
    logic [LEN_W-1:0]  rsp_len_r;
    logic              too_short;
    logic              bad_handle;
    logic              accept;
    logic              last;
    logic [RA-1:0]     dk;
    logic [31:0]       rom_dw;
    logic [31:0]       wdata;
    hdr0_t             h0;
    hdr2_t             h2;

    tar_wr_mbox #(.DEPTH(WMB_DEPTH)) u_wmb (
        .clk(clk), .rst(rst), .wen(mb_wr_en), .widx(mb_wr_idx),
        .wdata(mb_wr_data), .req(req)
    );

    assign too_short  = req.obj_len < LEN_FW'(REQ_DW);
    assign bad_handle = req.handle >= 16'(N_ENT);
    assign accept     = req_valid && (st == ST_IDLE) && !too_short && !bad_handle;
    assign last       = (LEN_FW'(ptr) == tot - LEN_FW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cur_ent   <= '0;
            ptr       <= '0;
            tot       <= '0;
            done_r    <= 1'b0;
            rsp_len_r <= '0;
        end else begin
            done_r <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        cur_ent <= req.handle[EW-1:0];
                        tot     <= hdr_len_dw(ent_len(req.handle[EW-1:0]));
                        ptr     <= '0;
                        st      <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    ptr <= ptr + RA'(1);
                    if (last) begin
                        st        <= ST_IDLE;
                        done_r    <= 1'b1;
                        rsp_len_r <= rsp_len_r + LEN_W'(tot);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign dk = ptr - RA'(HDR_DW);

    tar_rom #(.KW(RA), .MEM_SIZE(MEM_SIZE)) u_rom (
        .ent(cur_ent), .dw_k(dk), .dword(rom_dw)
    );

    always_comb begin
        h0.rsvd        = '0;
        h0.obj_type    = OBJ_TYPE;
        h0.vendor      = VENDOR;
        h2.rsp_code    = RSP_CODE;
        h2.tbl_type    = TBL_TYPE;
        h2.next_handle = (cur_ent == EW'(N_ENT - 1)) ? END_HANDLE
                                                     : 16'(cur_ent) + 16'd1;
        case (ptr)
            RA'(0):  wdata = h0;
            RA'(1):  wdata = 32'(tot);
            RA'(2):  wdata = h2;
            default: wdata = rom_dw;
        endcase
    end

    tar_rd_mbox #(.DEPTH(RMB_DEPTH)) u_rmb (
        .clk(clk), .rst(rst), .wen(st == ST_FILL), .widx(ptr), .wdata(wdata),
        .ridx(rsp_rd_idx), .rdata(rsp_rd_data)
    );

    assign busy    = (st == ST_FILL);
    assign done    = done_r;
    assign rsp_len = rsp_len_r;

    AST_SHORT_DROP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && too_short) |=> !busy); // R1
    AST_HANDLE_DROP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && bad_handle) |=> !busy); // R2
    AST_ENT_IN_ROM: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cur_ent < EW'(N_ENT))); // R2
    AST_LEN_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (rsp_len != $past(rsp_len)) |-> done); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(cur_ent)); // R10
endmodule

// File: tb/table_access_resp_bench.sv
`timescale 1ns/1ps
module table_access_resp_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] MSZ = 64'h1000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mb_wr_en = 1'b0;
    logic [2:0]  mb_wr_idx = '0;
    logic [31:0] mb_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  rsp_rd_idx = '0;
    logic [31:0] rsp_rd_data;
    logic [15:0] rsp_len;
    logic        busy;
    logic        done;

    table_access_resp u_table_access_resp (
        .clk(clk), .rst(rst), .mb_wr_en(mb_wr_en), .mb_wr_idx(mb_wr_idx),
        .mb_wr_data(mb_wr_data), .req_valid(req_valid), .rsp_rd_idx(rsp_rd_idx),
        .rsp_rd_data(rsp_rd_data), .rsp_len(rsp_len), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] exp_q[$];
    int          exp_tot_q[$];
    int          exp_len_acc = 0;
    int          done_seen = 0;
    int          busy_cnt = 0;
    logic [31:0] last_dw2 = '0;
    bit          finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Expected response built from the requirements (R3..R7)
    task automatic push_expected(input int h);
        logic [7:0] eb [32];
        int len, tot;
        logic [63:0] unit;
        logic [15:0] val;
        logic [7:0] kinds [4];
        kinds[0] = 8'd1; kinds[1] = 8'd2; kinds[2] = 8'd4; kinds[3] = 8'd5;
        for (int i = 0; i < 32; i++) eb[i] = 8'h00;
        len = (h == 0 || h == 5) ? 24 : 22;
        eb[0] = (h == 0) ? 8'd0 : (h == 5) ? 8'd4 : 8'd1;
        eb[2] = 8'(len);
        eb[3] = 8'(len >> 8);
        if (h == 0 || h == 5) begin
            eb[5] = (h == 0) ? 8'h04 : 8'h02;
            for (int i = 0; i < 8; i++) eb[16+i] = MSZ[8*i +: 8];
        end else begin
            unit = (h <= 2) ? 64'd10000 : 64'd1000;
            val  = (h == 1) ? 16'd15 : (h == 2) ? 16'd25 : 16'd16;
            eb[6] = kinds[h-1];
            for (int i = 0; i < 8; i++) eb[8+i] = unit[8*i +: 8];
            eb[16] = val[7:0];
            eb[17] = val[15:8];
        end
        tot = (12 + len + 3) / 4;
        exp_q.push_back({8'h00, 8'd2, 16'h1E98});
        exp_q.push_back(32'(tot));
        exp_q.push_back({(h == 5) ? 16'hFFFF : 16'(h + 1), 8'd0, 8'd0});
        for (int k = 0; k < tot - 3; k++)
            exp_q.push_back({eb[4*k+3], eb[4*k+2], eb[4*k+1], eb[4*k]});
        exp_tot_q.push_back(tot);
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (busy) busy_cnt++;
            if (done) begin
                int tot;
                done_seen++;
                if (exp_tot_q.size() == 0) begin
                    chk("R10 unexpected response", 32'd1, 32'd0);
                end else begin
                    tot = exp_tot_q.pop_front();
                    exp_len_acc += tot;
                    chk("R9 busy cycles", 32'(busy_cnt), 32'(tot));
                    chk("R9 busy low at done", 32'(busy), 32'd0);
                    chk("R8 rsp_len", 32'(rsp_len), 32'(exp_len_acc[15:0]));
                    for (int i = 0; i < tot; i++) begin
                        rsp_rd_idx = 4'(i);
                        #0.2;
                        if (i == 0)      chk("R3 hdr0", rsp_rd_data, exp_q.pop_front());
                        else if (i == 1) chk("R4 hdr1", rsp_rd_data, exp_q.pop_front());
                        else if (i == 2) begin
                            last_dw2 = rsp_rd_data;
                            chk("R5 hdr2", rsp_rd_data, exp_q.pop_front());
                        end else         chk("R6 R7 data", rsp_rd_data, exp_q.pop_front());
                    end
                end
                busy_cnt = 0;
            end
        end
    end

    task automatic write_dw(input int idx, input logic [31:0] d);
        @(negedge clk);
        mb_wr_en = 1'b1; mb_wr_idx = 3'(idx); mb_wr_data = d;
        @(negedge clk);
        mb_wr_en = 1'b0;
    endtask

    task automatic send_req(input int len, input logic [15:0] h);
        write_dw(0, {8'h00, 8'd2, 16'h1E98});
        write_dw(1, 32'(len));
        write_dw(2, {h, 8'd0, 8'd0});
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_req(input int len, input int h);
        int target;
        push_expected(h);
        target = done_seen + 1;
        send_req(len, 16'(h));
        while (done_seen < target) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic drop_req(input string tag, input int len, input logic [15:0] h);
        int d0;
        d0 = done_seen;
        send_req(len, h);
        repeat (12) begin
            chk({tag, " busy"}, 32'(busy), 32'd0);
            @(negedge clk);
        end
        chk({tag, " no done"}, 32'(done_seen), 32'(d0));
        chk({tag, " rsp_len"}, 32'(rsp_len), 32'(exp_len_acc[15:0]));
        rsp_rd_idx = 4'd2;
        #0.2;
        chk({tag, " mailbox"}, rsp_rd_data, last_dw2);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] h;
        int d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R11 done", 32'(done), 32'd0);
        chk("R11 rsp_len", 32'(rsp_len), 32'd0);

        // Walk the table through returned handles (R5)
        h = 16'd0;
        for (int it = 0; it < 8 && h != 16'hFFFF; it++) begin
            run_req(3, int'(h));
            h = last_dw2[31:16];
        end
        chk("R5 walk ends at sentinel", 32'(h), 32'h0000FFFF);

        // Longer-than-needed length is accepted
        run_req(10, 4);

        // Short requests (R1)
        drop_req("R1 len2", 2, 16'd0);
        drop_req("R1 len0", 0, 16'd1);
        // Handles out of range (R2)
        drop_req("R2 h6", 3, 16'd6);
        drop_req("R2 hFFFF", 3, 16'hFFFF);

        // Request during busy (R10)
        push_expected(2);
        d0 = done_seen;
        send_req(3, 16'd2);
        chk("R9 busy after accept", 32'(busy), 32'd1);
        write_dw(2, {16'd0, 8'd0, 8'd0});
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_seen < d0 + 1) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R10 single response", 32'(done_seen), 32'(d0 + 1));
        chk("R10 idle", 32'(busy), 32'd0);

        run_req(3, 0);
        run_req(3, 5);
        chk("R8 queue drained", 32'(exp_q.size()), 32'd0);
        summary();
    end
endmodule